// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Shadowed Settings

This block produces one pulse-width-modulated output. Its period comes from a 16-bit phase accumulator: on every clock while the block is enabled, the accumulator grows by a programmable step. Each carry out of the accumulator marks the end of one PWM period, so the output frequency equals the clock frequency times step / 65536. The duty cycle comes from an 8-bit threshold that is compared with the accumulator's top byte. The threshold is stored inverted: a larger value gives a shorter high time. Software derives it as 255 − 255 × duty.

Software controls the block through a single 32-bit control word on a plain register bus (write strobe, write data, read data). Writes land in shadow copies of the step and the threshold. The settings that actually run change only when software sets the update-request bit. While the output is running, that request is served at the next accumulator carry, so a period is never cut short or stretched. While the block is disabled, the request is served at once. The request bit reads back as 1 until the copy has happened.

Top module: `pwm_phase`

## Requirements
- R1: Control word layout: bit 31 is enable, bit 30 is update request, bits 23:8 are the step, bits 7:0 are the threshold. A read returns enable, the pending-request flag, and the shadow step and threshold. Bits 29:24 ignore writes and read as zero.
- R2: While enable is 0 the output is 0 and the accumulator is held at zero.
- R3: While enabled, the accumulator adds the running step on every clock. When the step divides 65536, the output period is 65536/step clocks.
- R4: While enabled, the output is 1 exactly when the accumulator's top byte is greater than or equal to the running threshold. A threshold of 0 gives a constant 1. A threshold above every top-byte value the accumulator reaches gives a constant 0.
- R5: A write with bit 30 clear changes only the shadow fields. The running waveform stays unchanged.
- R6: A write with bit 30 set while enabled takes effect at the first accumulator carry after the write, and not before.
- R7: After a write with bit 30 set while enabled, read bit 30 returns 1 until the settings are copied, then 0.
- R8: A write with bit 30 set while the block is disabled loads the running settings in the same cycle. If that write also sets enable, the first period starts from an accumulator of zero with the new settings.
- R9: A step of zero freezes the accumulator. The output then holds the level given by comparing zero with the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures period and high time from one rising edge to the next for several pairs of step and threshold. A design with an off-by-one compare would show one cycle too many or too few of high time, and one that mishandled the accumulator width would show the wrong period. It changes the threshold in the middle of a period with the update bit set and counts the high samples left in that period. A design that applies the change early drops the output before the carry, and one that never clears the request keeps bit 30 set. It also checks that a write without the update bit leaves the waveform alone, that enabling from idle starts with eight low samples for the mid-range threshold, and that a zero step holds a constant level.

// File: rtl/pwm_phase.sv
module pwm_phase #(
  parameter int SW = 16,
  parameter int TW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int RSV_W   = UPD_BIT - SW - TW;

  logic          en, pend;
  logic [SW-1:0] sh_step, act_step, acc;
  logic [TW-1:0] sh_thr, act_thr;
  logic [SW:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, act_step};

  wire wrap        = en & sum[SW];
  wire wr_upd      = wr_en & wr_data[UPD_BIT];
  wire load_direct = wr_upd & ~en;
  wire apply       = pend & (wrap | ~en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pend     <= 1'b0;
      sh_step  <= '0;
      sh_thr   <= '0;
      act_step <= '0;
      act_thr  <= '0;
      acc      <= '0;
    end else begin
      if (wr_en) begin
        en      <= wr_data[EN_BIT];
        sh_step <= wr_data[TW +: SW];
        sh_thr  <= wr_data[TW-1:0];
      end
      if (load_direct) begin
        act_step <= wr_data[TW +: SW];
        act_thr  <= wr_data[TW-1:0];
      end else if (apply) begin
        act_step <= sh_step;
        act_thr  <= sh_thr;
      end
      if (wr_upd && en)
        pend <= 1'b1;
      else if (apply)
        pend <= 1'b0;
      acc <= en ? sum[SW-1:0] : '0;
    end
  end

  assign pwm_out = en & (acc[SW-1 -: TW] >= act_thr);
  assign rd_data = {en, pend, {RSV_W{1'b0}}, sh_step, sh_thr};

endmodule

module pwm_phase_chk #(
  parameter int SW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          pwm_out,
  input logic          en,
  input logic          pend,
  input logic          wrap,
  input logic [SW-1:0] acc,
  input logic [SW-1:0] act_step,
  input logic [TW-1:0] act_thr
);
  a_r2_out_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  a_r2_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> acc == '0);
  a_r6_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pend && en && !wrap |=> $stable(act_step) && $stable(act_thr));
  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend && en && !wrap |=> pend);
  a_r5_change_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_thr) |-> $past(pend) || $past(wr_en && wr_data[30]));
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    en && act_step == '0 && !wr_en |=> $stable(acc));
endmodule

bind pwm_phase pwm_phase_chk #(.SW(SW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .pwm_out(pwm_out), .en(en), .pend(pend), .wrap(wrap),
  .acc(acc), .act_step(act_step), .act_thr(act_thr)
);

// File: tb/tb_pwm_phase.sv
module tb_pwm_phase;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        pwm_out;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  pwm_phase dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                 .rd_data(rd_data), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  localparam int NV = 12;
  localparam int V_STEP[NV] = '{4096, 4096, 4096, 8192, 8192, 16384, 1024, 32768, 4096, 4096, 0, 0};
  localparam int V_THR [NV] = '{128, 200, 1, 64, 100, 192, 128, 128, 0, 255, 0, 5};
  localparam int V_PER [NV] = '{16, 16, 16, 8, 8, 4, 64, 2, 0, 0, 0, 0};
  localparam int V_HI  [NV] = '{8, 3, 15, 6, 4, 1, 32, 1, 64, 0, 64, 0};

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  function automatic logic [31:0] word(int step, int thr);
    return (32'(step) << 8) | 32'(thr & 8'hff);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(output int per, output int hi);
    int prev, cur, n;
    prev = 1; cur = pwm_out; n = 0;
    while (!(prev == 0 && cur == 1) && n < 2000) begin
      prev = cur; @(negedge clk); cur = pwm_out; n++;
    end
    per = 0; hi = 0; prev = cur;
    for (int i = 0; i < 2000; i++) begin
      hi += cur; per++;
      @(negedge clk); cur = pwm_out;
      if (prev == 0 && cur == 1) break;
      prev = cur;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += pwm_out; @(negedge clk);
    end
  endtask

  initial begin
    int per, hi, first;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 0, "R1 reset readback", rd_data, 0);
    chk(pwm_out == 0, "R2 reset output", pwm_out, 0);

    wr(word(4096, 0));
    count_high(20, hi);
    chk(hi == 0, "R2 disabled output low", hi, 0);

    for (int v = 0; v < NV; v++) begin
      wr(0);
      wr(EN | UPD | word(V_STEP[v], V_THR[v]));
      if (V_PER[v] != 0) begin
        measure(per, hi);
        chk(per == V_PER[v], "R3 period", per, V_PER[v]);
        chk(hi == V_HI[v], "R4 high time", hi, V_HI[v]);
      end else begin
        count_high(64, hi);
        chk(hi == V_HI[v], V_STEP[v] == 0 ? "R9 frozen level" : "R4 constant level", hi, V_HI[v]);
      end
    end

    wr(32'h3F00_0000 | word(16'h1234, 8'h56));
    chk(rd_data == 32'h0012_3456, "R1 reserved bits read zero", rd_data, 32'h0012_3456);

    wr(0);
    wr(EN | UPD | word(4096, 128));
    first = -1;
    for (int i = 0; i < 16; i++) begin
      if (pwm_out && first < 0) first = i;
      @(negedge clk);
    end
    chk(first == 8, "R8 immediate load, start from zero", first, 8);

    wr(EN | word(8192, 64));
    chk(rd_data == (EN | word(8192, 64)), "R5 shadow readback", rd_data, EN | word(8192, 64));
    measure(per, hi);
    chk(per == 16 && hi == 8, "R5 waveform unchanged", per * 100 + hi, 1608);

    measure(per, hi);
    wr(EN | UPD | word(4096, 240));
    chk(rd_data[30] == 1, "R7 request pending", rd_data[30], 1);
    count_high(7, hi);
    chk(hi == 7, "R6 old threshold until wrap", hi, 7);
    chk(rd_data[30] == 0, "R7 request cleared after wrap", rd_data[30], 0);
    measure(per, hi);
    chk(per == 16 && hi == 1, "R6 new threshold after wrap", per * 100 + hi, 1601);

    wr(word(4096, 0));
    @(negedge clk);
    chk(pwm_out == 0, "R2 output low after disable", pwm_out, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule